// File: doc/BRIEF.md
# Prescaled Eight-Bit Timer with Split Nibble Reads

This block is an eight-bit up-counter driven from a power-of-two division of the core clock. Software selects one of four division ratios and turns the timer on or off through a small register interface. While the timer is off the count is held at zero. While it is on, the count advances once per prescaled tick and wraps from FFh to 00h without stopping. A sticky overflow flag marks each arrival at FFh, and software clears it by writing a one to a clear bit.

The data path of the register interface is four bits wide, so the count is read as two nibbles. Reading the low nibble also copies the high nibble of the same count value into a holding register. The high-nibble read then returns that copy, so a low-then-high read pair always describes one count value, even when a tick lands between the two reads.

Top module: `tmr8_nibread`

## Requirements
- R1: Select code s (control bits 2:1) divides the core clock by 2^(DIV_MIN_LOG2+3-s). With the default DIV_MIN_LOG2=10, code 00 gives 8192, 01 gives 4096, 10 gives 2048 and 11 gives 1024.
- R2: While the enable bit (control bit 0) is 0, the count reads 00h.
- R3: The prescaler restarts from zero while the timer is disabled. With division D, the count equals floor(k/D) mod 256 after k clock edges counted from the edge that sets the enable bit.
- R4: The overflow flag (control bit 3 on read) becomes 1 on the clock edge where the count steps from FEh to FFh.
- R5: After FFh the count continues to 00h, 01h and onward, repeating without end.
- R6: Once set, the flag stays 1 until a control write has bit 3 set to 1. A control write with bit 3 at 0 leaves the flag unchanged.
- R7: A read at address 1 returns count bits 3:0 and captures count bits 7:4 into the holding register on that clock edge.
- R8: A read at address 2 returns the holding register, so a read at address 1 followed by one at address 2 gives the two halves of a single count value.
- R9: If a flag-clear write falls on the same edge as an FEh-to-FFh step, the flag ends up set.
- R10: A read at address 0 returns {flag, select[1:0], enable} in bits 3..0. A write at address 0 loads enable from bit 0 and the select code from bits 2:1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (captures on address 1) |
| bus_addr | input | 2 | 0 control, 1 low nibble, 2 high nibble, 3 reads zero |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, combinational from address |

## Verification
If the prescaler phase were wrong, the count would show an off-by-one-tick error at the first read after enabling. That error would persist and scale across the full sweep, because every read is compared with floor(k/D). A flag that set on the wrong step, cleared itself, or lost the race against a clear would show on the control read within one cycle of the FFh arrival or of the clear write. A holding register that captured at the wrong moment would break the coherence of the nibble pair at reads where a tick lands between the low and high accesses. The sweep deliberately produces such reads.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // register addresses on the nibble bus
   typedef enum logic [1:0] {
      ADR_CTRL = 2'd0,
      ADR_LOW  = 2'd1,
      ADR_HIGH = 2'd2,
      ADR_NONE = 2'd3
   } tmr_addr_e;

   // number of prescale choices is fixed at four
   localparam int SEL_W    = 2;
   localparam int SEL_NUM  = 1 << SEL_W;

   // control layout
   localparam int CB_EN    = 0;
   localparam int CB_SEL_L = 1;
   localparam int CB_FLAG  = CB_SEL_L + SEL_W;
   localparam int CTRL_W   = CB_FLAG + 1;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
   import tmr_pkg::*;
#(
   parameter int DIV_MIN_LOG2 = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int PRE_W = DIV_MIN_LOG2 + SEL_NUM - 1;

   if (DIV_MIN_LOG2 < 1) begin : g_bad_div
      $error("tmr_prescale: DIV_MIN_LOG2 must be at least 1");
   end

   logic [PRE_W-1:0]   pre_q;
   logic [SEL_NUM-1:0] tick_opt;

   always_ff @(posedge clk) begin
      if (!rst_n)    pre_q <= '0;
      else if (!run) pre_q <= '0;
      else           pre_q <= pre_q + 1'b1;
   end

   // one terminal-count decode per select code
   for (genvar s = 0; s < SEL_NUM; s++) begin : g_opt
      localparam int TW = DIV_MIN_LOG2 + SEL_NUM - 1 - s;
      assign tick_opt[s] = &pre_q[TW-1:0];
   end

   assign tick = run & tick_opt[sel];
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             clr_req,
   output logic [CNT_W-1:0] cnt,
   output logic             flag
);
   localparam logic [CNT_W-1:0] PRE_TOP = {{(CNT_W-1){1'b1}}, 1'b0};

   logic hit_top;
   assign hit_top = run & tick & (cnt == PRE_TOP);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (!run) cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end

   // set has priority over a clear on the same edge
   always_ff @(posedge clk) begin
      if (!rst_n)       flag <= 1'b0;
      else if (hit_top) flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
   end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [1:0]           bus_addr,
   input  logic [CNT_W/2-1:0]   bus_wdata,
   output logic [CNT_W/2-1:0]   bus_rdata,
   input  logic [CNT_W-1:0]     cnt,
   input  logic                 flag,
   output logic                 run,
   output logic [SEL_W-1:0]     sel,
   output logic                 clr_req
);
   localparam int NIB_W = CNT_W / 2;

   logic [NIB_W-1:0] hold_q;
   logic             wr_ctrl;
   logic             rd_low;
   tmr_addr_e        adr;

   assign adr     = tmr_addr_e'(bus_addr);
   assign wr_ctrl = bus_wr & (adr == ADR_CTRL);
   assign rd_low  = bus_rd & (adr == ADR_LOW);
   assign clr_req = wr_ctrl & bus_wdata[CB_FLAG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run <= 1'b0;
         sel <= '0;
      end else if (wr_ctrl) begin
         run <= bus_wdata[CB_EN];
         sel <= bus_wdata[CB_SEL_L +: SEL_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      hold_q <= '0;
      else if (rd_low) hold_q <= cnt[CNT_W-1:NIB_W];
   end

   always_comb begin
      bus_rdata = '0;
      unique case (adr)
         ADR_CTRL: begin
            bus_rdata[CB_EN]             = run;
            bus_rdata[CB_SEL_L +: SEL_W] = sel;
            bus_rdata[CB_FLAG]           = flag;
         end
         ADR_LOW:  bus_rdata = cnt[NIB_W-1:0];
         ADR_HIGH: bus_rdata = hold_q;
         ADR_NONE: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tmr8_nibread.sv
module tmr8_nibread
   import tmr_pkg::*;
#(
   parameter int CNT_W        = 8,
   parameter int DIV_MIN_LOG2 = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [1:0]         bus_addr,
   input  logic [CNT_W/2-1:0] bus_wdata,
   output logic [CNT_W/2-1:0] bus_rdata
);
   localparam int NIB_W = CNT_W / 2;

   if (CNT_W % 2 != 0) begin : g_bad_even
      $error("tmr8_nibread: CNT_W must be even");
   end
   if (NIB_W < CTRL_W) begin : g_bad_nib
      $error("tmr8_nibread: nibble too narrow for control bits");
   end

   logic             run;
   logic             tick;
   logic             clr_req;
   logic             flag;
   logic [SEL_W-1:0] sel;
   logic [CNT_W-1:0] cnt;

   tmr_prescale #(.DIV_MIN_LOG2(DIV_MIN_LOG2)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .sel(sel), .tick(tick)
   );

   tmr_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
      .clr_req(clr_req), .cnt(cnt), .flag(flag)
   );

   tmr_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cnt(cnt), .flag(flag), .run(run), .sel(sel), .clr_req(clr_req)
   );
endmodule

// File: rtl/tmr8_checker.sv
module tmr8_checker #(
   parameter int CNT_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               run,
   input logic               tick,
   input logic               clr_req,
   input logic               flag,
   input logic [CNT_W-1:0]   cnt,
   input logic               bus_rd,
   input logic [1:0]         bus_addr,
   input logic [CNT_W/2-1:0] bus_rdata
);
   localparam int NIB_W = CNT_W / 2;
   localparam logic [CNT_W-1:0] PRE_TOP = {{(CNT_W-1){1'b1}}, 1'b0};
   localparam logic [CNT_W-1:0] TOP     = {CNT_W{1'b1}};

   p_hold_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));

   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick) |=> (cnt == $past(cnt) + 1'b1));

   p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(cnt));

   p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && cnt == PRE_TOP) |=> flag);

   p_rise_at_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> (cnt == TOP));

   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr_req) |=> flag);

   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !(run && tick && cnt == PRE_TOP)) |=> !flag);

   p_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 2'd1) |=>
         ((bus_addr == 2'd2) |-> (bus_rdata == $past(cnt[CNT_W-1:NIB_W]))));
endmodule

bind tmr8_nibread tmr8_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .clr_req(clr_req),
   .flag(flag), .cnt(cnt), .bus_rd(bus_rd), .bus_addr(bus_addr),
   .bus_rdata(bus_rdata)
);

// File: tb/sim_tmr8_nibread.sv
module sim_tmr8_nibread;
   localparam int MINL = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd3;
   logic [3:0] bus_wdata = 4'd0;
   logic [3:0] bus_rdata;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int en_cyc = 0;
   int clr_k  = 0;
   int div_d  = 1;
   int cur_sel = 0;
   bit cur_en = 0;

   tmr8_nibread #(.CNT_W(8), .DIV_MIN_LOG2(MINL)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int kk();
      return cyc - en_cyc;
   endfunction

   function automatic int exp_cnt(input int k);
      return cur_en ? ((k / div_d) % 256) : 0;
   endfunction

   // number of arrivals at FFh up to edge k
   function automatic int ev(input int k);
      if (k < 0) return 0;
      return ((k / div_d) + 1) / 256;
   endfunction

   function automatic bit exp_flag(input int k);
      return ev(k) > ev(clr_k - 1);
   endfunction

   task automatic wr_ctrl(input bit en, input int s, input bit clr);
      bit rising;
      rising = en && !cur_en;
      bus_wr = 1'b1; bus_addr = 2'd0;
      bus_wdata = {clr, s[1:0], en};
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 2'd3;
      cur_sel = s; cur_en = en;
      div_d = 1 << (MINL + 3 - s);
      if (rising) begin
         en_cyc = cyc;
         clr_k  = 0;
      end
      if (clr) clr_k = kk();
   endtask

   // R7 R8: coherent low/high pair compared with floor(k/D)
   task automatic read_pair(input string tag);
      int k, e, lo, hi;
      k = kk();
      e = exp_cnt(k);
      bus_rd = 1'b1; bus_addr = 2'd1;
      #1 lo = bus_rdata;
      @(negedge clk);
      bus_addr = 2'd2;
      #1 hi = bus_rdata;
      bus_rd = 1'b0; bus_addr = 2'd3;
      chk(lo == (e & 15), {tag, " R7 low nibble"}, lo, e & 15);
      chk(hi == (e >> 4), {tag, " R8 high nibble"}, hi, e >> 4);
   endtask

   // R10: control layout {flag, sel, en}
   task automatic read_ctrl(input string tag);
      int act, e;
      bus_addr = 2'd0;
      #1 act = bus_rdata;
      e = (int'(exp_flag(kk())) << 3) | (cur_sel << 1) | int'(cur_en);
      bus_addr = 2'd3;
      chk(act == e, {tag, " R10 control read"}, act, e);
   endtask

   task automatic wait_k(input int t);
      while (kk() < t) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      read_ctrl("reset");
      read_pair("reset R2");

      // R1 R3 R4 R5: sweep every select code across a full wrap
      for (int s = 0; s < 4; s++) begin
         wr_ctrl(1'b0, s, 1'b1);
         repeat (2) @(negedge clk);
         read_pair("disabled R2");
         wr_ctrl(1'b1, s, 1'b0);
         while (kk() < 300 * div_d) begin
            read_pair("sweep R1 R3 R5");
            read_ctrl("sweep R4");
            repeat (1 + (s % 3)) @(negedge clk);
         end
      end

      // focused flag checks on select 3
      wr_ctrl(1'b0, 3, 1'b1);
      repeat (2) @(negedge clk);
      wr_ctrl(1'b1, 3, 1'b0);
      wait_k(div_d - 1);
      read_ctrl("first tick pending R3");
      read_pair("first tick pending R3");
      wait_k(255 * div_d - 1);
      read_ctrl("just before FF R4");
      @(negedge clk);
      read_ctrl("at FF R4");
      wait_k(270 * div_d);
      read_ctrl("sticky across wrap R6");
      wr_ctrl(1'b1, 3, 1'b0);
      read_ctrl("write without clear R6");
      wr_ctrl(1'b1, 3, 1'b1);
      read_ctrl("after clear R6");
      read_pair("after clear R5");
      // R9: clear lands on the FEh->FFh edge
      wait_k(511 * div_d - 1);
      wr_ctrl(1'b1, 3, 1'b1);
      read_ctrl("set beats clear R9");
      chk(kk() == 511 * div_d, "R9 timing", kk(), 511 * div_d);
      read_pair("at second FF R4");
      // disable mid-run
      wr_ctrl(1'b0, 3, 1'b0);
      @(negedge clk);
      read_pair("disable mid-run R2");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 20);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule